// File: doc/BRIEF.md
# Windowed Rank Equalizer

This block performs local contrast stretching on a square neighbourhood of 8-bit grey pixels. Each clock it can take one complete window, presented as a single flat vector. It works out where the centre pixel stands within that window, which is the count of neighbours darker than it. A fixed table turns that position into an output grey level spread across the whole 0 to 255 scale. One result pixel leaves the block for every accepted window, and a valid flag goes with it.

The window side length is a parameter. The table is computed from the parameter at elaboration, so there is no divider in the datapath and nothing is loaded at run time. Line buffering, border handling and programmable tables belong to the logic around this block.

Top module: `rank_equalizer`

## Requirements
- R1: Pixel i of the window occupies bits [8i+7:8i] of `win_data`, row-major, and the centre pixel is index (NPIX-1)/2, where NPIX = WIN_DIM×WIN_DIM (index 4 for the default 3×3 window).
- R2: The rank of the centre is the number of the other window pixels whose value is strictly lower than the centre value. Pixels equal to the centre do not count.
- R3: The output level for rank r is r×255/(NPIX-1), rounded to the nearest integer with halves rounded up. For 3×3 the ranks 0..8 give 0, 32, 64, 96, 128, 159, 191, 223, 255.
- R4: Rank 0 always yields level 0, and rank NPIX-1 always yields level 255.
- R5: A window accepted with `win_vld` high at a rising edge produces `pix_vld` high with its result after exactly one more rising edge, a latency of two edges.
- R6: A synchronous active-high `rst` clears both pipeline valid bits and the output pixel. After the first edge with `rst` high, `pix_vld` is low, and a window that was in flight is discarded.
- R7: Window data presented while `win_vld` is low produces no output: `pix_vld` stays low.
- R8: Windows may arrive on every cycle back to back. Each one yields exactly one result, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | 1 | Window on `win_data` is valid this cycle |
| win_data | input | 8×NPIX | Flat window, pixel i at bits [8i+7:8i] |
| pix_vld | output | 1 | Result on `pix_out` is valid |
| pix_out | output | 8 | Equalized centre pixel |

## Verification
The bench aims at windows full of ties. A design that counted "lower or equal", or counted the centre against itself, would give a non-zero level for a flat window and a higher rank when duplicates are present. Windows with a single bright pixel placed either at the centre or at a corner expose a wrong centre index, because the two cases must give 255 and 0. Every rank from 0 to 8 is driven, which catches a table rounded down instead of to nearest (rank 4 would come out as 127). Bubbles, back-to-back streams and a reset that hits a window in flight would show a valid flag that is off by a cycle, duplicated or left standing.

// File: rtl/rank_eq_pkg.sv
package rank_eq_pkg;

  // Table entry: level for rank r in a window of npix pixels, rounded half up.
  function automatic int lut_level(input int r, input int npix, input int full);
    return (2 * r * full + (npix - 1)) / (2 * (npix - 1));
  endfunction

endpackage

// File: rtl/rank_eq_stage.sv
module rank_eq_stage #(
  parameter int PIX_W  = 8,
  parameter int NPIX   = 9,
  parameter int RANK_W = $clog2(NPIX)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [NPIX*PIX_W-1:0]   in_win,
  output logic                    rk_vld,
  output logic [RANK_W-1:0]       rk_val
);
  localparam int CTR = (NPIX - 1) / 2;
  localparam logic [RANK_W-1:0] ONE = RANK_W'(1);

  logic [PIX_W-1:0] pix [NPIX];
  logic [NPIX-1:0]  lower;
  logic [RANK_W-1:0] cnt;

  // Unpack the flat window and compare every neighbour against the centre.
  for (genvar i = 0; i < NPIX; i++) begin : g_cmp
    assign pix[i] = in_win[i*PIX_W +: PIX_W];
    if (i == CTR) begin : g_self
      assign lower[i] = 1'b0;
    end else begin : g_nbr
      assign lower[i] = (pix[i] < pix[CTR]);
    end
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (lower[i]) cnt = cnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rk_vld <= 1'b0;
      rk_val <= '0;
    end else begin
      rk_vld <= in_vld;
      rk_val <= cnt;
    end
  end

  // R2: a zero-valued centre has nothing strictly below it.
  p_zero_centre_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_win[CTR*PIX_W +: PIX_W] == '0) |=> (rk_val == '0));

endmodule

// File: rtl/rank_eq_lut.sv
module rank_eq_lut #(
  parameter int PIX_W  = 8,
  parameter int NPIX   = 9,
  parameter int RANK_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_vld,
  input  logic [RANK_W-1:0] rd_addr,
  output logic              q_vld,
  output logic [PIX_W-1:0]  q
);
  import rank_eq_pkg::*;

  localparam int DEPTH = 1 << RANK_W;
  localparam int FULL  = (1 << PIX_W) - 1;

  logic [PIX_W-1:0] tbl [DEPTH];

  // Constant table computed at elaboration; unused addresses read as zero.
  for (genvar r = 0; r < DEPTH; r++) begin : g_tbl
    if (r < NPIX) begin : g_used
      assign tbl[r] = PIX_W'(lut_level(r, NPIX, FULL));
    end else begin : g_pad
      assign tbl[r] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q     <= '0;
    end else begin
      q_vld <= rd_vld;
      q     <= tbl[rd_addr];
    end
  end

endmodule

// File: rtl/rank_equalizer.sv
module rank_equalizer #(
  parameter int WIN_DIM = 3,
  parameter int PIX_W   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  win_vld,
  input  logic [WIN_DIM*WIN_DIM*PIX_W-1:0]      win_data,
  output logic                                  pix_vld,
  output logic [PIX_W-1:0]                      pix_out
);
  localparam int NPIX   = WIN_DIM * WIN_DIM;
  localparam int RANK_W = $clog2(NPIX);
  localparam logic [RANK_W-1:0] RMAX = RANK_W'(NPIX - 1);

  logic              s1_vld;
  logic [RANK_W-1:0] s1_rank;

  rank_eq_stage #(.PIX_W(PIX_W), .NPIX(NPIX), .RANK_W(RANK_W)) u_stage (
    .clk(clk), .rst(rst), .in_vld(win_vld), .in_win(win_data),
    .rk_vld(s1_vld), .rk_val(s1_rank)
  );

  rank_eq_lut #(.PIX_W(PIX_W), .NPIX(NPIX), .RANK_W(RANK_W)) u_lut (
    .clk(clk), .rst(rst), .rd_vld(s1_vld), .rd_addr(s1_rank),
    .q_vld(pix_vld), .q(pix_out)
  );

  // R5: the valid flag advances one stage per edge.
  p_vld_stage1_r5: assert property (@(posedge clk) disable iff (rst)
    win_vld |=> s1_vld);
  p_vld_stage2_r5: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> pix_vld);
  // R4: both ends of the rank scale land on the ends of the grey scale.
  p_rank0_black_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_rank == '0) |=> (pix_out == '0));
  p_rankmax_white_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_rank == RMAX) |=> (pix_out == '1));
  // R6: one reset edge clears every valid bit.
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> (!s1_vld && !pix_vld));

endmodule

// File: tb/tb_rank_equalizer.sv
module tb_rank_equalizer;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_DIM = 3;
  localparam int PIX_W = 8;
  localparam int NPIX = WIN_DIM * WIN_DIM;
  localparam int CTR = (NPIX - 1) / 2;
  localparam int WW = NPIX * PIX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic win_vld = 1'b0;
  logic [WW-1:0] win_data = '0;
  logic pix_vld;
  logic [PIX_W-1:0] pix_out;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  rank_equalizer #(.WIN_DIM(WIN_DIM), .PIX_W(PIX_W)) dut (
    .clk(clk), .rst(rst), .win_vld(win_vld), .win_data(win_data),
    .pix_vld(pix_vld), .pix_out(pix_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int model(input logic [WW-1:0] w);
    int r = 0;
    int c = int'(w[CTR*PIX_W +: PIX_W]);
    for (int i = 0; i < NPIX; i++)
      if (i != CTR && int'(w[i*PIX_W +: PIX_W]) < c) r++;
    return $rtoi(real'(r) * 255.0 / real'(NPIX - 1) + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: present one window on the next falling edge and queue its expectation.
  task automatic send(input logic [WW-1:0] w, input string req);
    @(negedge clk);
    win_vld = 1'b1;
    win_data = w;
    exp_q.push_back(model(w));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n, input logic [WW-1:0] junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      win_vld = 1'b0;
      win_data = junk;
    end
  endtask

  function automatic logic [WW-1:0] mk(input int v [NPIX]);
    logic [WW-1:0] w;
    for (int i = 0; i < NPIX; i++) w[i*PIX_W +: PIX_W] = PIX_W'(v[i]);
    return w;
  endfunction

  // Monitor: compare each valid output against the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && pix_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected pix_vld", int'(pix_out), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(pix_out) == e, t, int'(pix_out), e);
      end
    end
  end

  initial begin
    int v [NPIX];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pix_vld == 1'b0, "R6 reset pix_vld", int'(pix_vld), 0);
    check(pix_out == '0, "R6 reset pix_out", int'(pix_out), 0);
    rst = 1'b0;

    // R2: flat window, all ties -> rank 0 -> level 0.
    v = '{7,7,7,7,7,7,7,7,7};
    send(mk(v), "R2 all equal");
    // R1: bright pixel at the centre -> rank 8 -> 255.
    v = '{10,10,10,10,200,10,10,10,10};
    send(mk(v), "R1 bright centre");
    // R1: bright pixel at a corner -> centre rank 0 -> 0.
    v = '{200,10,10,10,10,10,10,10,10};
    send(mk(v), "R1 bright corner");
    // R2: duplicates of the centre do not count.
    v = '{5,5,3,3,5,9,9,9,9};
    send(mk(v), "R2 ties with centre");
    // R4: extremes.
    v = '{1,2,3,4,0,5,6,7,8};
    send(mk(v), "R4 rank 0");
    v = '{0,1,2,3,255,4,5,6,7};
    send(mk(v), "R4 rank max");
    // R3: every rank 0..8 back to back.
    for (int r = 0; r < NPIX; r++) begin
      int k = 0;
      for (int i = 0; i < NPIX; i++) begin
        if (i == CTR) v[i] = 100;
        else begin
          v[i] = (k < r) ? 50 + k : 150 + k;
          k++;
        end
      end
      send(mk(v), "R3 rank sweep");
    end
    // R7: garbage while invalid.
    idle(4, {NPIX{8'hA5}});
    check(exp_q.size() == 0, "R5 drained after latency", exp_q.size(), 0);
    check(pix_vld == 1'b0, "R7 no output on bubbles", int'(pix_vld), 0);
    // R8: random stream with bubbles.
    for (int n = 0; n < 60; n++) begin
      logic [WW-1:0] w;
      for (int i = 0; i < NPIX; i++) w[i*PIX_W +: PIX_W] = PIX_W'($urandom_range(0, 15));
      if (n % 7 == 3) idle(1, w);
      send(w, "R8 stream");
    end
    idle(3, '0);
    check(exp_q.size() == 0, "R8 all results returned", exp_q.size(), 0);
    // R5: single window, exact latency.
    v = '{9,9,9,9,20,9,9,9,9};
    @(negedge clk);
    win_vld = 1'b1;
    win_data = mk(v);
    @(negedge clk);
    win_vld = 1'b0;
    check(pix_vld == 1'b0, "R5 not early", int'(pix_vld), 0);
    exp_q.push_back(model(mk(v)));
    tag_q.push_back("R5 latency value");
    @(negedge clk);
    check(pix_vld == 1'b1, "R5 valid after two edges", int'(pix_vld), 1);
    @(negedge clk);
    check(pix_vld == 1'b0, "R5 single pulse", int'(pix_vld), 0);
    // R6: reset discards a window in flight.
    @(negedge clk);
    win_vld = 1'b1;
    win_data = mk(v);
    @(negedge clk);
    win_vld = 1'b0;
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(pix_vld == 1'b0, "R6 in-flight dropped", int'(pix_vld), 0);
    end
    rst = 1'b0;
    idle(3, '0);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule